// File: doc/BRIEF.md
# Sprite Attribute Copy Engine

This block moves a fixed run of 160 bytes from a page that the CPU picks into sprite attribute memory. The copy runs at a fixed pace: one byte every four clock cycles. A single-cycle start strobe carries a 16-bit source base. The engine drives a memory port that it shares with the CPU's address decoder. In each transfer slot it issues one read cycle from the source and then one write cycle to the destination. While the copy runs, the CPU is fenced off from everything except a small high-RAM window, which sits inside the block. The CPU never has to compete with the engine for the shared port.

The controller has four states. IDLE waits for an accepted start. WAIT counts out the gap cycles of a slot. READ samples the source byte. WRITE stores that byte and advances the pointers. The transitions are as follows. IDLE→WAIT happens on an accepted start. WAIT→READ happens when the gap timer reaches zero. READ→WRITE is unconditional. WRITE→WAIT happens while bytes remain. WRITE→IDLE happens after the last byte. Any state goes to WAIT on an accepted start, which restarts the copy. With the default stride, WAIT lasts two cycles, so each slot takes four cycles.

Top module: `spr_dma`

## Requirements
- R1: Out of reset, `busy` is low and the memory port carries no request (`mem_req` low).
- R2: A start strobe whose base is above 0xF100 is ignored: `busy` stays low and no memory cycle is issued.
- R3: The first byte is written 4 cycles after the clock edge that samples an accepted start. It goes to address 0xFE00 and carries the byte read from the base address.
- R4: Byte k (k = 0..159) is written 4·k cycles after the first write, to 0xFE00+k. Exactly 160 writes are made, the last to 0xFE9F.
- R5: Each write is immediately preceded by a read cycle (`mem_req`=1, `mem_we`=0) at source base+k. The written data equals the byte returned by that read.
- R6: While busy, a CPU read of an address below 0xFF80 or of 0xFFFF returns 0xFF. A CPU write to such an address never reaches the memory port.
- R7: While busy, CPU reads and writes to 0xFF80–0xFFFE reach the internal high RAM normally.
- R8: `busy` rises in the cycle after an accepted start and falls in the cycle after the last byte's write.
- R9: An accepted start while busy restarts the copy from the new base, with the destination back at 0xFE00 and a full count of 160.
- R10: While idle, CPU accesses outside 0xFF80–0xFFFE pass to the memory port, and read data comes from `mem_rdata`. Accesses inside that window use the internal high RAM and issue no memory cycle.
- R11: A base of exactly 0xF100 is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle copy request |
| start_base | input | 16 | Source base address for the copy |
| busy | output | 1 | Copy in progress |
| cpu_req | input | 1 | CPU access valid this cycle |
| cpu_we | input | 1 | CPU access is a write |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rdata | output | 8 | CPU read data (combinational) |
| mem_req | output | 1 | Shared memory port cycle valid |
| mem_we | output | 1 | Shared memory port cycle is a write |
| mem_addr | output | 16 | Shared memory port address |
| mem_wdata | output | 8 | Shared memory port write data |
| mem_rdata | input | 8 | Shared memory port read data, valid in the same cycle |

## Verification
The hardest case to reach from the ports is a restart that lands in the middle of a copy. Its result can be confused with a copy that simply ran to completion. To catch it, the bench starts from one base and lets two bytes land. It then issues a second start with a different base on a gap cycle. The write log must show the two early bytes, followed by a fresh run of 160 that begins again at 0xFE00 with data from the new page. The lockout is probed in the middle of a copy. CPU reads, CPU writes and high-RAM accesses are interleaved with engine slots, and no foreign write may appear on the port.

// File: rtl/spr_dma_pkg.sv
package spr_dma_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WAIT  = 2'd1,
        ST_READ  = 2'd2,
        ST_WRITE = 2'd3
    } dma_state_t;
endpackage

// File: rtl/spr_dma_seq.sv
module spr_dma_seq
    import spr_dma_pkg::*;
#(
    parameter int          ADDR_W    = 16,
    parameter int          DATA_W    = 8,
    parameter int          XFER_LEN  = 160,
    parameter int          STRIDE    = 4,
    parameter logic [15:0] DEST_BASE = 16'hFE00,
    parameter logic [15:0] BASE_MAX  = 16'hF100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] start_base,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              busy,
    output logic              eng_rd,
    output logic              eng_wr,
    output logic [ADDR_W-1:0] eng_addr,
    output logic [DATA_W-1:0] eng_wdata
);
    // Slot = (STRIDE-2) gap cycles + one read + one write; STRIDE must be >= 3.
    localparam int GAP   = STRIDE - 2;
    localparam int GAP_W = (GAP > 1) ? $clog2(GAP) : 1;
    localparam int CNT_W = $clog2(XFER_LEN + 1);
    localparam logic [GAP_W-1:0] GAP_LOAD = GAP_W'(GAP - 1);
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(XFER_LEN);

    dma_state_t        state, state_nx;
    logic [ADDR_W-1:0] src_ptr, dst_ptr;
    logic [CNT_W-1:0]  remain;
    logic [GAP_W-1:0]  gap_tmr;
    logic [DATA_W-1:0] held;
    logic              start_ok;

    assign start_ok = start && (start_base <= ADDR_W'(BASE_MAX));

    // next-state
    always_comb begin
        state_nx = state;
        if (start_ok) begin
            state_nx = ST_WAIT;
        end else begin
            unique case (state)
                ST_IDLE:  state_nx = ST_IDLE;
                ST_WAIT:  state_nx = (gap_tmr == '0) ? ST_READ : ST_WAIT;
                ST_READ:  state_nx = ST_WRITE;
                ST_WRITE: state_nx = (remain == CNT_W'(1)) ? ST_IDLE : ST_WAIT;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // transfer datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_ptr <= '0;
            dst_ptr <= '0;
            remain  <= '0;
            gap_tmr <= '0;
            held    <= '0;
        end else if (start_ok) begin
            src_ptr <= start_base;
            dst_ptr <= ADDR_W'(DEST_BASE);
            remain  <= CNT_LOAD;
            gap_tmr <= GAP_LOAD;
        end else begin
            unique case (state)
                ST_IDLE: ;
                ST_WAIT: if (gap_tmr != '0) gap_tmr <= gap_tmr - 1'b1;
                ST_READ: held <= mem_rdata;
                ST_WRITE: begin
                    src_ptr <= src_ptr + 1'b1;
                    dst_ptr <= dst_ptr + 1'b1;
                    remain  <= remain - 1'b1;
                    gap_tmr <= GAP_LOAD;
                end
            endcase
        end
    end

    // outputs
    always_comb begin
        busy      = (state != ST_IDLE);
        eng_rd    = (state == ST_READ);
        eng_wr    = (state == ST_WRITE);
        eng_addr  = (state == ST_READ) ? src_ptr : dst_ptr;
        eng_wdata = held;
    end
endmodule

// File: rtl/spr_dma_hram.sv
module spr_dma_hram #(
    parameter int DEPTH  = 127,
    parameter int DATA_W = 8,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [IDX_W-1:0]  idx,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we && (int'(idx) < DEPTH)) cells[idx] <= wdata;
    end

    assign rdata = (int'(idx) < DEPTH) ? cells[idx] : '1;
endmodule

// File: rtl/spr_dma_gate.sv
module spr_dma_gate #(
    parameter int          ADDR_W  = 16,
    parameter int          DATA_W  = 8,
    parameter logic [15:0] HRAM_LO = 16'hFF80,
    parameter logic [15:0] HRAM_HI = 16'hFFFE,
    localparam int IDX_W = $clog2(int'(HRAM_HI) - int'(HRAM_LO) + 1)
) (
    input  logic              busy,
    input  logic              eng_rd,
    input  logic              eng_wr,
    input  logic [ADDR_W-1:0] eng_addr,
    input  logic [DATA_W-1:0] eng_wdata,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic [DATA_W-1:0] cpu_rdata,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic [DATA_W-1:0] hram_rdata,
    output logic              hram_we,
    output logic [IDX_W-1:0]  hram_idx,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata
);
    logic hram_hit, cpu_ext;
    logic [ADDR_W-1:0] offs;

    always_comb begin
        hram_hit = (cpu_addr >= ADDR_W'(HRAM_LO)) && (cpu_addr <= ADDR_W'(HRAM_HI));
        cpu_ext  = cpu_req && !hram_hit && !busy;
        offs     = cpu_addr - ADDR_W'(HRAM_LO);
        hram_idx = offs[IDX_W-1:0];
        hram_we  = cpu_req && cpu_we && hram_hit;

        mem_req   = eng_rd || eng_wr || cpu_ext;
        mem_we    = eng_wr || (cpu_ext && cpu_we);
        mem_addr  = busy ? eng_addr  : cpu_addr;
        mem_wdata = busy ? eng_wdata : cpu_wdata;

        if (hram_hit)  cpu_rdata = hram_rdata;
        else if (busy) cpu_rdata = '1;
        else           cpu_rdata = mem_rdata;
    end
endmodule

// File: rtl/spr_dma.sv
module spr_dma #(
    parameter int          ADDR_W    = 16,
    parameter int          DATA_W    = 8,
    parameter int          XFER_LEN  = 160,
    parameter int          STRIDE    = 4,
    parameter logic [15:0] DEST_BASE = 16'hFE00,
    parameter logic [15:0] BASE_MAX  = 16'hF100,
    parameter logic [15:0] HRAM_LO   = 16'hFF80,
    parameter logic [15:0] HRAM_HI   = 16'hFFFE
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] start_base,
    output logic              busy,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata
);
    localparam int HDEPTH = int'(HRAM_HI) - int'(HRAM_LO) + 1;
    localparam int HIDX_W = $clog2(HDEPTH);

    logic              eng_rd, eng_wr;
    logic [ADDR_W-1:0] eng_addr;
    logic [DATA_W-1:0] eng_wdata, hram_rdata;
    logic              hram_we;
    logic [HIDX_W-1:0] hram_idx;

    spr_dma_seq #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .XFER_LEN(XFER_LEN),
        .STRIDE(STRIDE), .DEST_BASE(DEST_BASE), .BASE_MAX(BASE_MAX)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .start_base(start_base),
        .mem_rdata(mem_rdata), .busy(busy), .eng_rd(eng_rd), .eng_wr(eng_wr),
        .eng_addr(eng_addr), .eng_wdata(eng_wdata)
    );

    spr_dma_gate #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .HRAM_LO(HRAM_LO), .HRAM_HI(HRAM_HI)
    ) u_gate (
        .busy(busy), .eng_rd(eng_rd), .eng_wr(eng_wr), .eng_addr(eng_addr),
        .eng_wdata(eng_wdata), .cpu_req(cpu_req), .cpu_we(cpu_we),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
        .mem_rdata(mem_rdata), .hram_rdata(hram_rdata), .hram_we(hram_we),
        .hram_idx(hram_idx), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata)
    );

    spr_dma_hram #(.DEPTH(HDEPTH), .DATA_W(DATA_W)) u_hram (
        .clk(clk), .we(hram_we), .idx(hram_idx), .wdata(cpu_wdata),
        .rdata(hram_rdata)
    );
endmodule

// File: rtl/spr_dma_chk.sv
module spr_dma_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        start,
    input logic [15:0] start_base,
    input logic        busy,
    input logic        cpu_req,
    input logic        cpu_we,
    input logic [15:0] cpu_addr,
    input logic [7:0]  cpu_rdata,
    input logic        mem_req,
    input logic        mem_we,
    input logic [15:0] mem_addr
);
    p_reset_quiet_r1: assert property (@(posedge clk)
        !rst_n |=> (!busy && !mem_req));

    p_bad_base_ignored_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start && start_base > 16'hF100) |=> !busy);

    p_write_in_oam_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && mem_req && mem_we) |-> (mem_addr >= 16'hFE00 && mem_addr <= 16'hFE9F));

    p_read_before_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && mem_req && mem_we) |-> $past(mem_req && !mem_we));

    p_locked_read_ff_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cpu_req && !cpu_we && (cpu_addr < 16'hFF80 || cpu_addr == 16'hFFFF))
        |-> cpu_rdata == 8'hFF);

    p_start_sets_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (start && start_base <= 16'hF100) |=> busy);

    p_busy_ends_on_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(mem_req && mem_we));
endmodule

bind spr_dma spr_dma_chk u_chk (.*);

// File: tb/spr_dma_bench.sv
module spr_dma_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [15:0] start_base = '0;
    logic        busy;
    logic        cpu_req = 1'b0, cpu_we = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic [7:0]  cpu_wdata = '0;
    logic [7:0]  cpu_rdata;
    logic        mem_req, mem_we;
    logic [15:0] mem_addr;
    logic [7:0]  mem_wdata, mem_rdata;

    always #4 clk = ~clk;

    spr_dma u_spr_dma (.*);

    function automatic logic [7:0] pat(input logic [15:0] a);
        return a[7:0] ^ a[15:8] ^ 8'h3C;
    endfunction
    assign mem_rdata = pat(mem_addr);

    localparam int LOGN = 400;
    int cyc = 0;
    int nw = 0, nr = 0;
    logic clr_log = 1'b0;
    int          w_cyc [LOGN];
    logic [15:0] w_adr [LOGN];
    logic [7:0]  w_dat [LOGN];
    int          r_cyc [LOGN];
    logic [15:0] r_adr [LOGN];

    always @(posedge clk) begin
        if (clr_log) begin
            nw <= 0; nr <= 0;
        end else begin
            if (mem_req && mem_we && nw < LOGN) begin
                w_cyc[nw] <= cyc; w_adr[nw] <= mem_addr; w_dat[nw] <= mem_wdata;
                nw <= nw + 1;
            end
            if (mem_req && !mem_we && busy && nr < LOGN) begin
                r_cyc[nr] <= cyc; r_adr[nr] <= mem_addr;
                nr <= nr + 1;
            end
        end
        cyc <= cyc + 1;
    end

    int total = 0, bad = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic clear_log();
        @(negedge clk) clr_log = 1'b1;
        @(negedge clk) clr_log = 1'b0;
    endtask

    task automatic wait_cyc(input int c);
        while (cyc < c) @(negedge clk);
    endtask

    task automatic pulse_start(input logic [15:0] b, output int c0);
        @(negedge clk);
        start = 1'b1; start_base = b; c0 = cyc;
        @(negedge clk);
        start = 1'b0;
    endtask

    // verify a log holding `n` writes from index `first`, run started at c0
    task automatic check_run(input int first, input int c0, input logic [15:0] b,
                             input string tag);
        int errs = 0;
        for (int k = 0; k < 160; k++) begin
            if (w_cyc[first+k] != c0 + 4 + 4*k || w_adr[first+k] != 16'hFE00 + k[15:0]
                || w_dat[first+k] != pat(b + k[15:0])) errs++;
        end
        chk(errs == 0, {tag, " R4 write sequence"}, errs, 0);
    endtask

    task automatic t_reset();
        chk(!busy, "R1 busy after reset", busy, 0);
        chk(!mem_req, "R1 mem_req after reset", mem_req, 0);
    endtask

    task automatic t_bad_base();
        int c0;
        clear_log();
        pulse_start(16'hF101, c0);
        chk(!busy, "R2 busy after rejected start", busy, 0);
        wait_cyc(c0 + 12);
        chk(!busy && nw == 0 && nr == 0, "R2 no activity", nw + nr, 0);
    endtask

    task automatic t_full(input logic [15:0] b, input string tag);
        int c0, errs;
        clear_log();
        pulse_start(b, c0);
        chk(busy, {tag, " R8 busy after start"}, busy, 1);
        wait_cyc(c0 + 640);
        chk(busy, {tag, " R8 busy before last write"}, busy, 1);
        wait_cyc(c0 + 641);
        chk(!busy, {tag, " R8 idle after last write"}, busy, 0);
        wait_cyc(c0 + 646);
        chk(nw == 160, {tag, " R4 write count"}, nw, 160);
        chk(w_cyc[0] == c0 + 4 && w_adr[0] == 16'hFE00 && w_dat[0] == pat(b),
            {tag, " R3 first write"}, w_cyc[0] - c0, 4);
        chk(w_adr[159] == 16'hFE9F, {tag, " R4 last dest"}, w_adr[159], 16'hFE9F);
        check_run(0, c0, b, tag);
        errs = 0;
        for (int k = 0; k < 160; k++)
            if (r_cyc[k] != c0 + 3 + 4*k || r_adr[k] != b + k[15:0]) errs++;
        chk(nr == 160 && errs == 0, {tag, " R5 read precedes write"}, errs, 0);
    endtask

    task automatic t_lockout();
        int c0, stray;
        clear_log();
        pulse_start(16'hC000, c0);
        wait_cyc(c0 + 20);
        cpu_req = 1'b1; cpu_we = 1'b0; cpu_addr = 16'hC123;
        #1 chk(cpu_rdata == 8'hFF, "R6 locked read", cpu_rdata, 8'hFF);
        cpu_addr = 16'hFFFF;
        #1 chk(cpu_rdata == 8'hFF, "R6 locked read FFFF", cpu_rdata, 8'hFF);
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            cpu_we = 1'b1; cpu_addr = 16'hC000 + 16'(i); cpu_wdata = 8'hA5;
        end
        @(negedge clk);
        cpu_we = 1'b1; cpu_addr = 16'hFF90; cpu_wdata = 8'h5A;
        @(negedge clk);
        cpu_we = 1'b0;
        #1 chk(cpu_rdata == 8'h5A, "R7 hram readback while busy", cpu_rdata, 8'h5A);
        @(negedge clk) cpu_req = 1'b0;
        wait_cyc(c0 + 646);
        stray = 0;
        for (int k = 0; k < nw; k++)
            if (w_adr[k] < 16'hFE00 || w_adr[k] > 16'hFE9F) stray++;
        chk(stray == 0 && nw == 160, "R6 dropped writes", stray, 0);
    endtask

    task automatic t_restart();
        int c0, c1;
        clear_log();
        pulse_start(16'hC000, c0);
        wait_cyc(c0 + 9);
        @(negedge clk);
        start = 1'b1; start_base = 16'hD000; c1 = cyc;
        @(negedge clk) start = 1'b0;
        wait_cyc(c1 + 646);
        chk(nw == 162, "R9 write count with restart", nw, 162);
        chk(w_adr[1] == 16'hFE01 && w_dat[1] == pat(16'hC001), "R9 pre-restart bytes",
            w_adr[1], 16'hFE01);
        check_run(2, c1, 16'hD000, "R9 restart");
    endtask

    task automatic t_idle_pass();
        clear_log();
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = 1'b0; cpu_addr = 16'hC0A5;
        #1 chk(cpu_rdata == pat(16'hC0A5) && mem_req && mem_addr == 16'hC0A5,
               "R10 idle external read", cpu_rdata, pat(16'hC0A5));
        @(negedge clk);
        cpu_we = 1'b1; cpu_addr = 16'hC010; cpu_wdata = 8'h66;
        @(negedge clk);
        cpu_addr = 16'hFF85; cpu_wdata = 8'h77;
        @(negedge clk);
        cpu_we = 1'b0;
        #1 chk(cpu_rdata == 8'h77 && !mem_req, "R10 idle hram internal", cpu_rdata, 8'h77);
        @(negedge clk) cpu_req = 1'b0;
        @(negedge clk);
        chk(nw == 1 && w_adr[0] == 16'hC010 && w_dat[0] == 8'h66,
            "R10 idle write forwarded once", nw, 1);
    endtask

    task automatic finish_up();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        #(8 * 200000);
        bad++; total++;
        $display("FAIL watchdog expired actual=%0d expected=done", cyc);
        finish_up();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_bad_base();
        t_full(16'hC000, "base C000");
        t_full(16'hF100, "R11 base F100");
        t_full(16'h0200, "base 0200");
        t_lockout();
        t_restart();
        t_idle_pass();
        finish_up();
    end
endmodule